// File: doc/BRIEF.md
# Bus Hang Recovery Flush Controller

This block lets a hung host bus recover without disturbing the rest of the controller. While a bus-initialization level is seen on `busInit`, every outstanding-request queue (host-bus cycles, in-flight memory transactions and inbound transactions) is emptied. In the same cycles the round-robin service arbiter and its grant output return to their idle defaults.

The flush is selective. The configuration register and the sticky error-status bits keep their values. The per-port link-up indications keep following their training inputs. The periodic memory-refresh strobe keeps its exact cadence. Only the separate hard reset `hardRstN` clears everything, sticky bits included. Software can therefore read the error history after a bus-init event, and a full restart still needs a hard reset.

Requests enter one of three queues through a valid/ready pair. A `serve` strobe retires one entry from the next non-empty queue in round-robin order and reports the served queue on a one-hot grant in the following cycle.

Top module: `bus_hang_flush`

## Requirements
- R1: When `hardRstN` is low, all queue counts, `qValid`, `grantVec`, `cfgRdData`, `errStatus` and `linkUp` are zero, and `refreshReq` is low. Once `hardRstN` is high and `busInit` is low, `reqReady` is high for a valid queue code that has room.
- R2: The queue codes on `reqQueue` are 0 for host bus, 1 for memory and 2 for inbound. Code 3 is never ready. A cycle with `reqValid` and `reqReady` high adds one entry to the selected queue. `reqReady` is low when that queue already holds `QDEPTH` entries. Bit i of `qValid` is high exactly when queue i is non-empty. Queue i's count sits in `qCount[i*CNT_W +: CNT_W]`.
- R3: In a cycle with `serve` high, the arbiter takes the first non-empty queue, searching from its pointer upward with wrap-around. It removes one entry from that queue, raises that queue's bit of `grantVec` in the next cycle, and moves the pointer to the queue after the served one. The pointer is 0 after any reset or flush. If every queue is empty, `serve` raises no grant. An accept and a serve in the same cycle are both applied.
- R4: In every cycle `busInit` is sampled high, all queue counts and `grantVec` are zero in the next cycle, and the arbiter pointer returns to 0.
- R5: `reqReady` is low in every cycle `busInit` is high and in the one cycle after it falls.
- R6: `cfgRdData` takes `cfgWrData` one cycle after a `cfgWrEn` cycle. It never changes for any other reason, and `busInit` has no effect on it.
- R7: Each cycle, `errStatus` becomes (old AND NOT `errClr`) OR `errSet`, so a set wins over a clear on the same bit. `busInit` never changes it.
- R8: `linkUp` equals `linkTrained` delayed by one cycle, whatever the state of `busInit`.
- R9: `refreshReq` is a one-cycle pulse exactly every `REFRESH_PERIOD` cycles, and `busInit` neither delays nor advances it.
- R10: A `serve` in a cycle where `busInit` is high retires nothing and raises no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hardRstN | input | 1 | Asynchronous active-low hard reset, clears all state |
| busInit | input | 1 | Bus-initialization level, flushes tracking state |
| reqValid | input | 1 | New request present |
| reqQueue | input | 2 | Target queue code of the request |
| reqReady | output | 1 | Request can be accepted this cycle |
| serve | input | 1 | Retire one entry via the arbiter |
| grantVec | output | 3 | One-hot queue served in the previous cycle |
| qValid | output | 3 | Per-queue non-empty flags |
| qCount | output | 3*CNT_W | Packed per-queue entry counts |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | CFG_W | Configuration write value |
| cfgRdData | output | CFG_W | Configuration register contents |
| errSet | input | ERR_W | Per-bit error set pulses |
| errClr | input | ERR_W | Per-bit write-one-to-clear |
| errStatus | output | ERR_W | Sticky error bits |
| linkTrained | input | NUM_LINKS | Per-port training complete |
| linkUp | output | NUM_LINKS | Registered per-port link status |
| refreshReq | output | 1 | Periodic memory-refresh pulse |

## Verification
The bench drives `busInit` while requests, serves, config writes and error pulses are still active. A design that wiped configuration or sticky bits on that event, or that dropped link status, shows a mismatch at once. It checks the cycle after `busInit` falls, where a design that reopened `reqReady` too early would take a request and a count would then be off by one. It holds `busInit` high for longer than a refresh period. A refresh counter that was reset or frozen by the flush would show a wrong pulse spacing. It also fills a queue to `QDEPTH`, serves with every queue empty and uses the unused queue code, and compares the hard-reset path, which must clear the sticky bits that bus-init keeps.

// File: rtl/hfc_pkg.sv
package hfc_pkg;
  localparam int NUM_Q  = 3;
  localparam int QSEL_W = 2;

  typedef struct packed {
    logic flush;
    logic block;
  } hfcStrobe_t;
endpackage

// File: rtl/hfc_ctrl.sv
module hfc_ctrl
  import hfc_pkg::*;
#(
  parameter int REFRESH_PERIOD = 64
) (
  input  logic       clk,
  input  logic       hardRstN,
  input  logic       busInit,
  output hfcStrobe_t strb,
  output logic       refreshReq
);
  localparam int RW = $clog2(REFRESH_PERIOD);
  localparam logic [RW-1:0] REF_LAST = RW'(REFRESH_PERIOD - 1);

  logic          busInitQ;
  logic [RW-1:0] refCnt;

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      busInitQ <= 1'b0;
      refCnt   <= '0;
    end else begin
      busInitQ <= busInit;
      refCnt   <= (refCnt == REF_LAST) ? '0 : refCnt + 1'b1;
    end
  end

  assign refreshReq = hardRstN && (refCnt == REF_LAST);
  assign strb.flush = busInit;
  assign strb.block = busInit | busInitQ;
endmodule

// File: rtl/hfc_datapath.sv
module hfc_datapath
  import hfc_pkg::*;
#(
  parameter int QDEPTH    = 15,
  parameter int CFG_W     = 16,
  parameter int ERR_W     = 8,
  parameter int NUM_LINKS = 2,
  localparam int CNT_W    = $clog2(QDEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   hardRstN,
  input  hfcStrobe_t             strb,
  input  logic                   reqValid,
  input  logic [QSEL_W-1:0]      reqQueue,
  output logic                   reqReady,
  input  logic                   serve,
  output logic [NUM_Q-1:0]       grantVec,
  output logic [NUM_Q-1:0]       qValid,
  output logic [NUM_Q*CNT_W-1:0] qCount,
  input  logic                   cfgWrEn,
  input  logic [CFG_W-1:0]       cfgWrData,
  output logic [CFG_W-1:0]       cfgRdData,
  input  logic [ERR_W-1:0]       errSet,
  input  logic [ERR_W-1:0]       errClr,
  output logic [ERR_W-1:0]       errStatus,
  input  logic [NUM_LINKS-1:0]   linkTrained,
  output logic [NUM_LINKS-1:0]   linkUp
);
  logic [CNT_W-1:0]  qCnt [NUM_Q];
  logic [NUM_Q-1:0]  qFull, incVec, decVec, readyVec;
  logic [QSEL_W-1:0] rrPtr, pick;
  logic              found;
  int                idx;

  // round-robin search from the pointer
  always_comb begin
    found = 1'b0;
    pick  = '0;
    idx   = 0;
    for (int k = 0; k < NUM_Q; k++) begin
      idx = int'(rrPtr) + k;
      if (idx >= NUM_Q) idx = idx - NUM_Q;
      if (!found && qValid[idx]) begin
        found = 1'b1;
        pick  = QSEL_W'(idx);
      end
    end
  end

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    assign qFull[i]    = (qCnt[i] == CNT_W'(QDEPTH));
    assign qValid[i]   = (qCnt[i] != '0);
    assign readyVec[i] = (reqQueue == QSEL_W'(i)) && !qFull[i];
    assign incVec[i]   = reqValid && reqReady && (reqQueue == QSEL_W'(i));
    assign decVec[i]   = serve && found && !strb.flush && (pick == QSEL_W'(i));
    assign qCount[i*CNT_W +: CNT_W] = qCnt[i];

    always_ff @(posedge clk or negedge hardRstN) begin
      if (!hardRstN)       qCnt[i] <= '0;
      else if (strb.flush) qCnt[i] <= '0;
      else begin
        case ({incVec[i], decVec[i]})
          2'b10:   qCnt[i] <= qCnt[i] + 1'b1;
          2'b01:   qCnt[i] <= qCnt[i] - 1'b1;
          default: qCnt[i] <= qCnt[i];
        endcase
      end
    end
  end

  assign reqReady = !strb.block && (|readyVec);

  // arbiter state: flushed by bus-init
  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      rrPtr    <= '0;
      grantVec <= '0;
    end else if (strb.flush) begin
      rrPtr    <= '0;
      grantVec <= '0;
    end else if (serve && found) begin
      grantVec <= NUM_Q'(1) << pick;
      rrPtr    <= (pick == QSEL_W'(NUM_Q - 1)) ? '0 : pick + 1'b1;
    end else begin
      grantVec <= '0;
    end
  end

  // preserved state: only the hard reset clears it
  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      cfgRdData <= '0;
      errStatus <= '0;
      linkUp    <= '0;
    end else begin
      if (cfgWrEn) cfgRdData <= cfgWrData;
      errStatus <= (errStatus & ~errClr) | errSet;
      linkUp    <= linkTrained;
    end
  end
endmodule

// File: rtl/bus_hang_flush.sv
module bus_hang_flush
  import hfc_pkg::*;
#(
  parameter int QDEPTH         = 15,
  parameter int CFG_W          = 16,
  parameter int ERR_W          = 8,
  parameter int NUM_LINKS      = 2,
  parameter int REFRESH_PERIOD = 64,
  localparam int CNT_W         = $clog2(QDEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   hardRstN,
  input  logic                   busInit,
  input  logic                   reqValid,
  input  logic [1:0]             reqQueue,
  output logic                   reqReady,
  input  logic                   serve,
  output logic [2:0]             grantVec,
  output logic [2:0]             qValid,
  output logic [3*CNT_W-1:0]     qCount,
  input  logic                   cfgWrEn,
  input  logic [CFG_W-1:0]       cfgWrData,
  output logic [CFG_W-1:0]       cfgRdData,
  input  logic [ERR_W-1:0]       errSet,
  input  logic [ERR_W-1:0]       errClr,
  output logic [ERR_W-1:0]       errStatus,
  input  logic [NUM_LINKS-1:0]   linkTrained,
  output logic [NUM_LINKS-1:0]   linkUp,
  output logic                   refreshReq
);
  hfcStrobe_t strb;

  hfc_ctrl #(.REFRESH_PERIOD(REFRESH_PERIOD)) ctrl_i (
    .clk(clk), .hardRstN(hardRstN), .busInit(busInit),
    .strb(strb), .refreshReq(refreshReq)
  );

  hfc_datapath #(
    .QDEPTH(QDEPTH), .CFG_W(CFG_W), .ERR_W(ERR_W), .NUM_LINKS(NUM_LINKS)
  ) dp_i (
    .clk(clk), .hardRstN(hardRstN), .strb(strb),
    .reqValid(reqValid), .reqQueue(reqQueue), .reqReady(reqReady),
    .serve(serve), .grantVec(grantVec), .qValid(qValid), .qCount(qCount),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .errSet(errSet), .errClr(errClr), .errStatus(errStatus),
    .linkTrained(linkTrained), .linkUp(linkUp)
  );
endmodule

// File: rtl/bus_hang_flush_chk.sv
module bus_hang_flush_chk #(
  parameter int QDEPTH         = 15,
  parameter int CFG_W          = 16,
  parameter int ERR_W          = 8,
  parameter int NUM_LINKS      = 2,
  parameter int REFRESH_PERIOD = 64,
  localparam int CNT_W         = $clog2(QDEPTH + 1)
) (
  input logic                 clk,
  input logic                 hardRstN,
  input logic                 busInit,
  input logic                 reqReady,
  input logic                 serve,
  input logic [2:0]           grantVec,
  input logic [3*CNT_W-1:0]   qCount,
  input logic                 cfgWrEn,
  input logic [CFG_W-1:0]     cfgRdData,
  input logic [ERR_W-1:0]     errSet,
  input logic [ERR_W-1:0]     errClr,
  input logic [ERR_W-1:0]     errStatus,
  input logic [NUM_LINKS-1:0] linkTrained,
  input logic [NUM_LINKS-1:0] linkUp,
  input logic                 refreshReq
);
  logic        prevInit, seenRef;
  logic [15:0] refGap;

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      prevInit <= 1'b0;
      seenRef  <= 1'b0;
      refGap   <= '0;
    end else begin
      prevInit <= busInit;
      if (refreshReq) begin
        seenRef <= 1'b1;
        refGap  <= '0;
      end else begin
        refGap <= refGap + 1'b1;
      end
    end
  end

  a_r4_flush_empties: assert property (@(posedge clk) disable iff (!hardRstN)
    busInit |=> (qCount == '0) && (grantVec == '0));

  a_r5_ready_blocked: assert property (@(posedge clk) disable iff (!hardRstN)
    (busInit || prevInit) |-> !reqReady);

  a_r6_cfg_stable: assert property (@(posedge clk) disable iff (!hardRstN)
    !cfgWrEn |=> $stable(cfgRdData));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!hardRstN)
    (errSet == '0 && errClr == '0) |=> $stable(errStatus));

  a_r8_link_kept: assert property (@(posedge clk) disable iff (!hardRstN)
    (busInit && linkTrained == '1) |=> linkUp == '1);

  a_r9_refresh_spacing: assert property (@(posedge clk) disable iff (!hardRstN)
    (refreshReq && seenRef) |-> refGap == 16'(REFRESH_PERIOD - 1));

  a_r9_refresh_single: assert property (@(posedge clk) disable iff (!hardRstN)
    refreshReq |=> !refreshReq);

  a_r3_grant_onehot: assert property (@(posedge clk) disable iff (!hardRstN)
    $onehot0(grantVec));

  a_r10_no_grant_in_flush: assert property (@(posedge clk) disable iff (!hardRstN)
    (busInit && serve) |=> grantVec == '0);
endmodule

bind bus_hang_flush bus_hang_flush_chk #(
  .QDEPTH(QDEPTH), .CFG_W(CFG_W), .ERR_W(ERR_W),
  .NUM_LINKS(NUM_LINKS), .REFRESH_PERIOD(REFRESH_PERIOD)
) chk_i (
  .clk(clk), .hardRstN(hardRstN), .busInit(busInit), .reqReady(reqReady),
  .serve(serve), .grantVec(grantVec), .qCount(qCount), .cfgWrEn(cfgWrEn),
  .cfgRdData(cfgRdData), .errSet(errSet), .errClr(errClr),
  .errStatus(errStatus), .linkTrained(linkTrained), .linkUp(linkUp),
  .refreshReq(refreshReq)
);

// File: tb/bus_hang_flush_tb_top.sv
module bus_hang_flush_tb_top;
  localparam int QDEPTH = 15;
  localparam int CNT_W  = 4;
  localparam int PERIOD = 64;

  logic        clk = 1'b0;
  logic        hardRstN = 1'b0;
  logic        busInit = 1'b0, reqValid = 1'b0, serve = 1'b0, cfgWrEn = 1'b0;
  logic [1:0]  reqQueue = '0;
  logic [15:0] cfgWrData = '0;
  logic [7:0]  errSet = '0, errClr = '0;
  logic [1:0]  linkTrained = '0;
  logic        reqReady, refreshReq;
  logic [2:0]  grantVec, qValid;
  logic [11:0] qCount;
  logic [15:0] cfgRdData;
  logic [7:0]  errStatus;
  logic [1:0]  linkUp;

  always #2 clk = ~clk;

  bus_hang_flush dut_i (
    .clk(clk), .hardRstN(hardRstN), .busInit(busInit), .reqValid(reqValid),
    .reqQueue(reqQueue), .reqReady(reqReady), .serve(serve),
    .grantVec(grantVec), .qValid(qValid), .qCount(qCount),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .errSet(errSet), .errClr(errClr), .errStatus(errStatus),
    .linkTrained(linkTrained), .linkUp(linkUp), .refreshReq(refreshReq)
  );

  int checks = 0, fails = 0;
  int mCnt [3];
  int mPtr;
  logic [2:0]  mGrant;
  logic [15:0] mCfg;
  logic [7:0]  mErr;
  logic [1:0]  mLink;
  bit          mPrevInit;
  bit          done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit expReady(input bit bi, input logic [1:0] rq);
    if (bi || mPrevInit) return 0;
    if (rq == 2'd3) return 0;
    return mCnt[rq] < QDEPTH;
  endfunction

  function automatic logic [2:0] expValid();
    logic [2:0] v;
    for (int i = 0; i < 3; i++) v[i] = (mCnt[i] != 0);
    return v;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 3; i++) mCnt[i] = 0;
    mPtr = 0; mGrant = '0; mCfg = '0; mErr = '0; mLink = '0; mPrevInit = 0;
  endtask

  task automatic checkState();
    for (int i = 0; i < 3; i++)
      chk(qCount[i*CNT_W +: CNT_W] == CNT_W'(mCnt[i]), "R2 R4", "qCount",
          qCount[i*CNT_W +: CNT_W], mCnt[i]);
    chk(qValid == expValid(), "R2", "qValid", qValid, expValid());
    chk(grantVec == mGrant, "R3 R10", "grantVec", grantVec, mGrant);
    chk(cfgRdData == mCfg, "R6", "cfgRdData", cfgRdData, mCfg);
    chk(errStatus == mErr, "R7", "errStatus", errStatus, mErr);
    chk(linkUp == mLink, "R8", "linkUp", linkUp, mLink);
  endtask

  task automatic step(input bit bi, input bit rv, input logic [1:0] rq,
                      input bit sv, input bit cw, input logic [15:0] cd,
                      input logic [7:0] es, input logic [7:0] ec,
                      input logic [1:0] lt);
    bit er, acc, found;
    int pick;
    @(negedge clk);
    checkState();
    busInit = bi; reqValid = rv; reqQueue = rq; serve = sv;
    cfgWrEn = cw; cfgWrData = cd; errSet = es; errClr = ec; linkTrained = lt;
    #1;
    er = expReady(bi, rq);
    chk(reqReady == er, (bi || mPrevInit) ? "R5" : "R2", "reqReady", reqReady, er);
    acc = rv && er;
    found = 0; pick = 0;
    for (int k = 0; k < 3; k++) begin
      int ix = (mPtr + k) % 3;
      if (!found && mCnt[ix] != 0) begin found = 1; pick = ix; end
    end
    if (bi) begin
      for (int i = 0; i < 3; i++) mCnt[i] = 0;
      mPtr = 0; mGrant = '0;
    end else begin
      if (sv && found) begin
        mCnt[pick]--; mGrant = 3'(1) << pick; mPtr = (pick + 1) % 3;
      end else mGrant = '0;
      if (acc) mCnt[rq]++;
    end
    if (cw) mCfg = cd;
    mErr = (mErr & ~ec) | es;
    mLink = lt;
    mPrevInit = bi;
  endtask

  task automatic idle(input int n, input bit bi);
    for (int i = 0; i < n; i++) step(bi, 0, 2'd0, 0, 0, 16'h0, 8'h0, 8'h0, linkTrained);
  endtask

  task automatic doHardReset();
    @(negedge clk);
    hardRstN = 0; busInit = 0; reqValid = 0; serve = 0; cfgWrEn = 0;
    errSet = '0; errClr = '0; linkTrained = '0;
    refSeen = 0;
    modelReset();
    @(negedge clk);
    checkState();  // R1 reset state
    chk(refreshReq == 1'b0, "R1", "refreshReq in reset", refreshReq, 0);
    @(negedge clk);
    hardRstN = 1;
  endtask

  // R9 refresh spacing monitor
  int  cyc = 0, lastRef = 0, pulses = 0;
  bit  refSeen = 0;
  always @(negedge clk) begin
    if (hardRstN && !done) begin
      cyc++;
      if (refreshReq) begin
        if (refSeen) chk(cyc - lastRef == PERIOD, "R9", "refresh interval",
                         cyc - lastRef, PERIOD);
        lastRef = cyc; refSeen = 1; pulses++;
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    modelReset();
    doHardReset();  // R1
    // R2 fill host queue past full
    for (int i = 0; i < QDEPTH + 2; i++) step(0, 1, 2'd0, 0, 0, 0, 0, 0, 2'b11);
    chk(qCount[3:0] == 4'(QDEPTH), "R2", "full host queue", qCount[3:0], QDEPTH);
    // R2 invalid code 3
    step(0, 1, 2'd3, 0, 0, 0, 0, 0, 2'b11);
    step(0, 1, 2'd1, 0, 0, 0, 0, 0, 2'b11);
    step(0, 1, 2'd2, 0, 0, 0, 0, 0, 2'b11);
    // R3 round robin, serve plus accept together
    for (int i = 0; i < 5; i++) step(0, 1, 2'd2, 1, 0, 0, 0, 0, 2'b11);
    // config, errors, set wins over clear (R6 R7)
    step(0, 0, 0, 0, 1, 16'hBEEF, 8'h5A, 8'h00, 2'b11);
    step(0, 0, 0, 0, 0, 0, 8'h01, 8'h41, 2'b11);
    // R4 R5 R10 bus-init with traffic and serves
    for (int i = 0; i < 3; i++) step(1, 1, 2'd1, 1, 0, 0, 0, 0, 2'b11);
    step(0, 1, 2'd1, 1, 0, 0, 0, 0, 2'b11);  // R5 cycle after fall
    step(0, 0, 0, 0, 0, 0, 0, 0, 2'b11);
    chk(qCount == '0, "R4", "queues empty after flush", qCount, 0);
    chk(cfgRdData == 16'hBEEF, "R6", "cfg kept", cfgRdData, 16'hBEEF);
    chk(errStatus == 8'h1B, "R7", "sticky kept", errStatus, 8'h1B);
    chk(linkUp == 2'b11, "R8", "link kept", linkUp, 2'b11);
    // R3 serve with all empty
    step(0, 0, 0, 1, 0, 0, 0, 0, 2'b11);
    step(0, 0, 0, 0, 0, 0, 0, 0, 2'b11);
    chk(grantVec == '0, "R3", "no grant when empty", grantVec, 0);
    // R9 long bus-init spanning several refresh periods
    idle(150, 1);
    idle(70, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit bi = ($urandom % 40) == 0;
      step(bi, 1'($urandom), 2'($urandom), 1'($urandom % 3 == 0),
           1'($urandom % 8 == 0), 16'($urandom), 8'(($urandom % 6 == 0) ? $urandom : 0),
           8'(($urandom % 5 == 0) ? $urandom : 0), ($urandom % 20 == 0) ? 2'b01 : 2'b11);
    end
    // R1 hard reset clears what bus-init kept
    doHardReset();
    chk(errStatus == '0, "R1", "sticky cleared by hard reset", errStatus, 0);
    chk(cfgRdData == '0, "R1", "cfg cleared by hard reset", cfgRdData, 0);
    step(0, 1, 2'd0, 0, 0, 0, 0, 0, 2'b00);  // R1 ready after release
    idle(3, 0);
    chk(pulses >= 40, "R9", "refresh pulses seen", pulses, 40);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule